// File: doc/BRIEF.md
# Set-Associative Translation Cache with Range Invalidation

This block keeps recently used address translations in a set-associative array and answers lookups by virtual address with either a hit, carrying the physical address and a two-bit permission, or a miss. A page-table walker, which is outside the block, supplies refills that carry the page size: 4 KiB, 64 KiB or 1 MiB. The set index is always taken from virtual address bits [17:12] of the address that missed. A 4 KiB translation therefore lands in exactly one set. A 64 KiB translation can sit in any of the 16 consecutive sets its region spans. A 1 MiB translation can sit in any set.

Software keeps the cache coherent with page-table edits through a small register write port. It offers three ways to drop entries. The first clears the whole array at once. The second clears the entries covering one 4 KiB page, and only in that page's set. The third clears every entry that overlaps an inclusive page range, using a sweep that visits one set per cycle. While the sweep runs, a busy flag is high and every lookup reports a miss.

Top module: `tlb_range_inv`

## Requirements
- R1: After reset every entry is invalid, `rngBusy` is low and `rspValid` and `rspHit` are low. A lookup issued right after reset misses.
- R2: A lookup presented with `lkValid` high gets its response on the next cycle with `rspValid` high. On a hit, `rspPerm` is the stored permission and `rspPa` is formed from the stored frame bits above the page size and the lookup address bits below it.
- R3: Refill size codes are 0 for 4 KiB, 1 for 64 KiB and 2 for 1 MiB. An entry is placed in the set given by `rfVa[17:12]`. It hits only for lookups whose `lkVa[17:12]` names the same set and whose address lies inside the entry's page.
- R4: When several valid entries in the looked-up set cover the address, the smallest page wins.
- R5: Each set replaces its ways in round-robin order. After WAYS+1 distinct refills into one set, the first one is gone and the rest still hit.
- R6: A write to offset 0x10 with data bit 0 set invalidates every entry. With bit 0 clear, the write has no effect.
- R7: A write to offset 0x14 with data bit 0 set invalidates, in set data[17:12] only, each entry whose page covers the 4 KiB page data[31:12]. Entries of the same page that sit in other sets survive. With bit 0 clear, the write has no effect.
- R8: Offsets 0x20 and 0x24 hold the inclusive first and last page of a range, taken from data[31:12]. A write to 0x18 with bit 0 set starts a sweep that invalidates every entry, in any set, whose page overlaps the range. Entries outside the range survive.
- R9: A sweep holds `rngBusy` high for exactly SETS cycles. During the sweep, lookups miss, refills are dropped, and writes to 0x18, 0x20 and 0x24 are ignored.
- R10: A refill with size code 3 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | VA_W | Lookup virtual address |
| rspValid | output | 1 | Lookup response present (one cycle after request) |
| rspHit | output | 1 | Response is a hit |
| rspPa | output | PA_W | Translated physical address |
| rspPerm | output | 2 | Permission of the hitting entry |
| rfValid | input | 1 | Refill strobe |
| rfVa | input | VA_W | Refill virtual address |
| rfPa | input | PA_W | Refill physical frame address |
| rfSize | input | 2 | Refill page size code |
| rfPerm | input | 2 | Refill permission |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | VA_W | Register write data |
| rngBusy | output | 1 | Range sweep in progress |

## Verification
The bench uses the default build: 64 sets, 8 ways and 32-bit addresses. With these values, a 1 MiB entry can be filled through set 63, and a 64 KiB entry can be placed in two different sets of its own 16-set span. The single-page clear is then shown to remove the copy in one set and leave the copy in the other. The full 64-cycle sweep length can be counted, and a range can catch large pages whose sets lie far outside the range's own indices. With eight ways, nine fills into one set are enough to show the round-robin eviction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PG_SHIFT = 12;

  localparam logic [1:0] SZ_4K  = 2'd0;
  localparam logic [1:0] SZ_64K = 2'd1;
  localparam logic [1:0] SZ_1M  = 2'd2;
  localparam logic [1:0] SZ_BAD = 2'd3;

  localparam logic [7:0] OFS_FLUSH_ALL = 8'h10;
  localparam logic [7:0] OFS_FLUSH_ONE = 8'h14;
  localparam logic [7:0] OFS_RNG_GO    = 8'h18;
  localparam logic [7:0] OFS_RNG_LO    = 8'h20;
  localparam logic [7:0] OFS_RNG_HI    = 8'h24;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic flushOne;
    logic sweepEn;
    logic busy;
  } ctrlStrb_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl import tlb_pkg::*; #(
  parameter int VA_W = 32,
  parameter int SETS = 64,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [VA_W-1:0]  regWdata,
  output ctrlStrb_t        strb,
  output logic [VPN_W-1:0] oneVpn,
  output logic [VPN_W-1:0] rngLo,
  output logic [VPN_W-1:0] rngHi,
  output logic [SET_W-1:0] sweepSet
);
  logic busyQ;
  logic [SET_W-1:0] setQ;
  logic goWr;
  logic unusedBits;

  assign unusedBits = ^regWdata[PG_SHIFT-1:1];
  assign goWr = regWe && (regAddr == OFS_RNG_GO) && regWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      setQ  <= '0;
      rngLo <= '0;
      rngHi <= '0;
    end else begin
      if (!busyQ && regWe && regAddr == OFS_RNG_LO) rngLo <= regWdata[VA_W-1:PG_SHIFT];
      if (!busyQ && regWe && regAddr == OFS_RNG_HI) rngHi <= regWdata[VA_W-1:PG_SHIFT];
      if (busyQ) begin
        if (setQ == SET_W'(SETS - 1)) begin
          busyQ <= 1'b0;
          setQ  <= '0;
        end else begin
          setQ <= setQ + 1'b1;
        end
      end else if (goWr) begin
        busyQ <= 1'b1;
        setQ  <= '0;
      end
    end
  end

  always_comb begin
    strb.flushAll = regWe && (regAddr == OFS_FLUSH_ALL) && regWdata[0];
    strb.flushOne = regWe && (regAddr == OFS_FLUSH_ONE) && regWdata[0];
    strb.sweepEn  = busyQ;
    strb.busy     = busyQ;
  end

  assign oneVpn   = regWdata[VA_W-1:PG_SHIFT];
  assign sweepSet = setQ;
endmodule

// File: rtl/tlb_array.sv
module tlb_array import tlb_pkg::*; #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PPN_W = PA_W - PG_SHIFT,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [VPN_W-1:0] oneVpn,
  input  logic [VPN_W-1:0] rngLo,
  input  logic [VPN_W-1:0] rngHi,
  input  logic [SET_W-1:0] sweepSet,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVa,
  input  logic             rfValid,
  input  logic [VA_W-1:0]  rfVa,
  input  logic [PA_W-1:0]  rfPa,
  input  logic [1:0]       rfSize,
  input  logic [1:0]       rfPerm,
  output logic             rspValid,
  output logic             rspHit,
  output logic [PA_W-1:0]  rspPa,
  output logic [1:0]       rspPerm
);
  typedef struct packed {
    logic             v;
    logic [1:0]       sz;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       perm;
  } ent_t;

  ent_t mem [SETS][WAYS];
  logic [WAY_W-1:0] rr [SETS];

  function automatic int lowBits(input logic [1:0] s);
    case (s)
      SZ_64K:  return 4;
      SZ_1M:   return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic covers(input ent_t e, input logic [VPN_W-1:0] vpn);
    logic [VPN_W-1:0] low;
    low = (VPN_W'(1) << lowBits(e.sz)) - VPN_W'(1);
    return e.v && (((e.vpn ^ vpn) & ~low) == '0);
  endfunction

  function automatic logic overlaps(input ent_t e, input logic [VPN_W-1:0] lo,
                                    input logic [VPN_W-1:0] hi);
    logic [VPN_W-1:0] low;
    low = (VPN_W'(1) << lowBits(e.sz)) - VPN_W'(1);
    return e.v && ((e.vpn & ~low) <= hi) && ((e.vpn | low) >= lo);
  endfunction

  logic [VPN_W-1:0] lkVpn;
  logic [SET_W-1:0] lkSet, rfSet, oneSet;
  logic             selHit;
  logic [WAY_W-1:0] selWay;
  logic [1:0]       bestSz;
  ent_t             selEnt, newEnt;
  logic [PPN_W-1:0] lowP, paPage;
  logic             unusedBits;

  assign unusedBits = ^{rfVa[PG_SHIFT-1:0], rfPa[PG_SHIFT-1:0]};
  assign lkVpn  = lkVa[VA_W-1:PG_SHIFT];
  assign lkSet  = lkVa[PG_SHIFT +: SET_W];
  assign rfSet  = rfVa[PG_SHIFT +: SET_W];
  assign oneSet = oneVpn[SET_W-1:0];

  // lookup: smallest covering page wins, lowest way breaks ties
  always_comb begin
    selHit = 1'b0;
    selWay = '0;
    bestSz = SZ_BAD;
    for (int w = 0; w < WAYS; w++) begin
      if (covers(mem[lkSet][w], lkVpn) && (mem[lkSet][w].sz < bestSz)) begin
        selHit = 1'b1;
        selWay = WAY_W'(w);
        bestSz = mem[lkSet][w].sz;
      end
    end
    selEnt = mem[lkSet][selWay];
    lowP   = (PPN_W'(1) << lowBits(selEnt.sz)) - PPN_W'(1);
    paPage = (selEnt.ppn & ~lowP) | (PPN_W'(lkVpn) & lowP);
  end

  always_comb begin
    newEnt.v    = 1'b1;
    newEnt.sz   = rfSize;
    newEnt.vpn  = rfVa[VA_W-1:PG_SHIFT];
    newEnt.ppn  = rfPa[PA_W-1:PG_SHIFT];
    newEnt.perm = rfPerm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPa    <= '0;
      rspPerm  <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid && selHit && !strb.busy;
      rspPa    <= (lkValid && selHit && !strb.busy) ? {paPage, lkVa[PG_SHIFT-1:0]} : '0;
      rspPerm  <= (lkValid && selHit && !strb.busy) ? selEnt.perm : 2'b00;
    end
  end

  // entry state: refill, then invalidations (invalidations win)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        rr[s] <= '0;
        for (int w = 0; w < WAYS; w++) mem[s][w].v <= 1'b0;
      end
    end else begin
      if (rfValid && !strb.busy && (rfSize != SZ_BAD)) begin
        mem[rfSet][rr[rfSet]] <= newEnt;
        rr[rfSet] <= (rr[rfSet] == WAY_W'(WAYS - 1)) ? '0 : rr[rfSet] + 1'b1;
      end
      if (strb.flushOne) begin
        for (int w = 0; w < WAYS; w++)
          if (covers(mem[oneSet][w], oneVpn)) mem[oneSet][w].v <= 1'b0;
      end
      if (strb.sweepEn) begin
        for (int w = 0; w < WAYS; w++)
          if (overlaps(mem[sweepSet][w], rngLo, rngHi)) mem[sweepSet][w].v <= 1'b0;
      end
      if (strb.flushAll) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) mem[s][w].v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_range_inv.sv
module tlb_range_inv import tlb_pkg::*; #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [VA_W-1:0] lkVa,
  output logic            rspValid,
  output logic            rspHit,
  output logic [PA_W-1:0] rspPa,
  output logic [1:0]      rspPerm,
  input  logic            rfValid,
  input  logic [VA_W-1:0] rfVa,
  input  logic [PA_W-1:0] rfPa,
  input  logic [1:0]      rfSize,
  input  logic [1:0]      rfPerm,
  input  logic            regWe,
  input  logic [7:0]      regAddr,
  input  logic [VA_W-1:0] regWdata,
  output logic            rngBusy
);
  ctrlStrb_t        strb;
  logic [VPN_W-1:0] oneVpn, rngLo, rngHi;
  logic [SET_W-1:0] sweepSet;

  tlb_ctrl #(.VA_W(VA_W), .SETS(SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .oneVpn(oneVpn), .rngLo(rngLo), .rngHi(rngHi), .sweepSet(sweepSet)
  );

  tlb_array #(.VA_W(VA_W), .PA_W(PA_W), .SETS(SETS), .WAYS(WAYS)) u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .oneVpn(oneVpn), .rngLo(rngLo), .rngHi(rngHi),
    .sweepSet(sweepSet), .lkValid(lkValid), .lkVa(lkVa), .rfValid(rfValid), .rfVa(rfVa),
    .rfPa(rfPa), .rfSize(rfSize), .rfPerm(rfPerm), .rspValid(rspValid), .rspHit(rspHit),
    .rspPa(rspPa), .rspPerm(rspPerm)
  );

  assign rngBusy = strb.busy;
endmodule

// File: rtl/tlb_range_inv_chk.sv
module tlb_range_inv_chk #(
  parameter int VA_W = 32,
  parameter int SETS = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic            rspValid,
  input logic            rspHit,
  input logic            regWe,
  input logic [7:0]      regAddr,
  input logic [VA_W-1:0] regWdata,
  input logic            rngBusy
);
  logic [$clog2(SETS):0] busyCnt;
  logic unusedBits;
  assign unusedBits = ^regWdata[VA_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= rngBusy ? busyCnt + 1'b1 : '0;
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  assert_hit_has_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);
  assert_flush_all_misses_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 8'h10 && regWdata[0]) ##1 lkValid |=> !rspHit);
  assert_sweep_starts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 8'h18 && regWdata[0] && !rngBusy) |=> rngBusy);
  assert_busy_misses_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rngBusy && lkValid) |=> !rspHit);
  assert_sweep_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    rngBusy |-> (busyCnt < SETS));
  assert_sweep_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rngBusy) |-> (busyCnt == SETS));
endmodule

bind tlb_range_inv tlb_range_inv_chk #(.VA_W(VA_W), .SETS(SETS)) u_chk (.*);

// File: tb/tb_tlb_range_inv.sv
`timescale 1ns/1ps
module tb_tlb_range_inv;
  localparam int SETS = 64;
  localparam int WAYS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [31:0] lkVa = '0;
  logic rspValid, rspHit, rngBusy;
  logic [31:0] rspPa;
  logic [1:0] rspPerm;
  logic rfValid = 1'b0;
  logic [31:0] rfVa = '0, rfPa = '0;
  logic [1:0] rfSize = '0, rfPerm = '0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;

  int checks = 0;
  int errors = 0;
  logic gotValid, gotHit;
  logic [31:0] gotPa;
  logic [1:0] gotPerm;

  always #4 clk = ~clk;

  tlb_range_inv #(.VA_W(32), .PA_W(32), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .rspValid(rspValid),
    .rspHit(rspHit), .rspPa(rspPa), .rspPerm(rspPerm), .rfValid(rfValid), .rfVa(rfVa),
    .rfPa(rfPa), .rfSize(rfSize), .rfPerm(rfPerm), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rngBusy(rngBusy)
  );

  // op: 0 refill(a=va,b=pa), 1 lookup(a=va), 2 register write(addr,a=data)
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  sz;
    logic [1:0]  perm;
    logic        expHit;
    logic [31:0] expPa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 32'h0000_5000, 32'hAAAA_A000, 2'd0, 2'd3, 1'b0, 32'h0, 4'd2},  // R2 fill 4K
    '{2'd1, 8'h00, 32'h0000_5123, 32'h0, 2'd0, 2'd3, 1'b1, 32'hAAAA_A123, 4'd2},  // R2 hit
    '{2'd1, 8'h00, 32'h0000_6123, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd3},          // R3 next page
    '{2'd1, 8'h00, 32'h0100_5000, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd3},          // R3 tag differs
    '{2'd0, 8'h00, 32'h0012_3000, 32'hBBBB_0000, 2'd1, 2'd1, 1'b0, 32'h0, 4'd3},  // R3 fill 64K
    '{2'd1, 8'h00, 32'h0012_3ABC, 32'h0, 2'd0, 2'd1, 1'b1, 32'hBBBB_3ABC, 4'd3},  // R3 64K hit
    '{2'd1, 8'h00, 32'h0012_4000, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd3},          // R3 other set
    '{2'd0, 8'h00, 32'h0012_3000, 32'hCCCC_C000, 2'd0, 2'd2, 1'b0, 32'h0, 4'd4},  // R4 overlap 4K
    '{2'd1, 8'h00, 32'h0012_3010, 32'h0, 2'd0, 2'd2, 1'b1, 32'hCCCC_C010, 4'd4},  // R4 small wins
    '{2'd0, 8'h00, 32'h0573_F000, 32'hD000_0000, 2'd2, 2'd1, 1'b0, 32'h0, 4'd3},  // R3 fill 1M set 63
    '{2'd1, 8'h00, 32'h0573_FFFF, 32'h0, 2'd0, 2'd1, 1'b1, 32'hD003_FFFF, 4'd3},  // R3 1M hit
    '{2'd1, 8'h00, 32'h0570_0000, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd3},          // R3 1M other set
    '{2'd0, 8'h00, 32'h0012_4000, 32'hBBBB_0000, 2'd1, 2'd1, 1'b0, 32'h0, 4'd7},  // R7 64K copy set 0x24
    '{2'd2, 8'h10, 32'h0000_0000, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd6},          // R6 bit0 clear
    '{2'd1, 8'h00, 32'h0000_5123, 32'h0, 2'd0, 2'd3, 1'b1, 32'hAAAA_A123, 4'd6},  // R6 no effect
    '{2'd2, 8'h14, 32'h0012_3000, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd7},          // R7 bit0 clear
    '{2'd1, 8'h00, 32'h0012_3010, 32'h0, 2'd0, 2'd2, 1'b1, 32'hCCCC_C010, 4'd7},  // R7 no effect
    '{2'd2, 8'h14, 32'h0012_3001, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd7},          // R7 invalidate page
    '{2'd1, 8'h00, 32'h0012_3010, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd7},          // R7 both gone
    '{2'd1, 8'h00, 32'h0012_4020, 32'h0, 2'd0, 2'd1, 1'b1, 32'hBBBB_4020, 4'd7},  // R7 other set kept
    '{2'd1, 8'h00, 32'h0000_5123, 32'h0, 2'd0, 2'd3, 1'b1, 32'hAAAA_A123, 4'd7},  // R7 unrelated kept
    '{2'd2, 8'h10, 32'h0000_0001, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd6},          // R6 flush all
    '{2'd1, 8'h00, 32'h0000_5123, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd6},          // R6
    '{2'd1, 8'h00, 32'h0573_FFFF, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd6},          // R6
    '{2'd1, 8'h00, 32'h0012_4020, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, 4'd6}           // R6
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic doRefill(input logic [31:0] va, input logic [31:0] pa,
                          input logic [1:0] sz, input logic [1:0] perm);
    rfValid = 1'b1; rfVa = va; rfPa = pa; rfSize = sz; rfPerm = perm;
    @(negedge clk);
    rfValid = 1'b0;
  endtask

  task automatic doLookup(input logic [31:0] va);
    lkValid = 1'b1; lkVa = va;
    @(negedge clk);
    lkValid = 1'b0;
    gotValid = rspValid; gotHit = rspHit; gotPa = rspPa; gotPerm = rspPerm;
  endtask

  task automatic doWrite(input logic [7:0] addr, input logic [31:0] data);
    regWe = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic expectLk(input logic [31:0] va, input logic expHit, input logic [31:0] expPa,
                          input logic [1:0] expPerm, input string req);
    doLookup(va);
    check(gotValid === 1'b1, req, "rspValid", {31'b0, gotValid}, 32'd1);
    check(gotHit === expHit, req, "rspHit", {31'b0, gotHit}, {31'b0, expHit});
    if (expHit && gotHit) begin
      check(gotPa === expPa, req, "rspPa", gotPa, expPa);
      check(gotPerm === expPerm, req, "rspPerm", {30'b0, gotPerm}, {30'b0, expPerm});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int busyCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(rspValid === 1'b0, "R1", "rspValid", {31'b0, rspValid}, 32'd0);
    check(rngBusy === 1'b0, "R1", "rngBusy", {31'b0, rngBusy}, 32'd0);
    expectLk(32'h0000_0000, 1'b0, 32'h0, 2'd0, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: doRefill(VEC[i].a, VEC[i].b, VEC[i].sz, VEC[i].perm);
        2'd1: expectLk(VEC[i].a, VEC[i].expHit, VEC[i].expPa, VEC[i].perm,
                       $sformatf("R%0d", VEC[i].req));
        default: doWrite(VEC[i].addr, VEC[i].a);
      endcase
    end

    // R5: round-robin eviction in set 5
    for (int i = 0; i <= WAYS; i++)
      doRefill((32'(i) << 18) | 32'h0000_5000, 32'h1000_0000 + (32'(i) << 12), 2'd0, 2'd3);
    expectLk(32'h0000_5000, 1'b0, 32'h0, 2'd0, "R5");
    for (int i = 1; i <= WAYS; i++)
      expectLk((32'(i) << 18) | 32'h0000_5004, 1'b1, 32'h1000_0004 + (32'(i) << 12), 2'd3, "R5");

    // R8: range sweep over pages 0x00203..0x00204 inclusive
    doWrite(8'h10, 32'h1);
    doRefill(32'h0020_3000, 32'h1111_1000, 2'd0, 2'd3);  // start page: dies
    doRefill(32'h0020_4000, 32'h1212_1000, 2'd0, 2'd3);  // end page: dies
    doRefill(32'h0020_5000, 32'h2222_2000, 2'd0, 2'd3);  // after end: lives
    doRefill(32'h0020_2000, 32'h3333_3000, 2'd0, 2'd3);  // before start: lives
    doRefill(32'h0030_1000, 32'h4440_0000, 2'd2, 2'd3);  // 1M no overlap: lives
    doRefill(32'h0010_7000, 32'h5550_0000, 2'd2, 2'd3);  // 1M no overlap: lives
    doRefill(32'h0020_8000, 32'h6666_0000, 2'd1, 2'd3);  // 64K in set 8 overlaps: dies
    doRefill(32'h002F_F000, 32'h7770_0000, 2'd2, 2'd3);  // 1M in set 63 overlaps: dies
    doWrite(8'h20, 32'h0020_3000);
    doWrite(8'h24, 32'h0020_4000);
    doWrite(8'h18, 32'h1);
    check(rngBusy === 1'b1, "R8", "rngBusy after trigger", {31'b0, rngBusy}, 32'd1);
    while (rngBusy) @(negedge clk);
    expectLk(32'h0020_3000, 1'b0, 32'h0, 2'd0, "R8");
    expectLk(32'h0020_4FFF, 1'b0, 32'h0, 2'd0, "R8");
    expectLk(32'h0020_8000, 1'b0, 32'h0, 2'd0, "R8");
    expectLk(32'h002F_F000, 1'b0, 32'h0, 2'd0, "R8");
    expectLk(32'h0020_5004, 1'b1, 32'h2222_2004, 2'd3, "R8");
    expectLk(32'h0020_2008, 1'b1, 32'h3333_3008, 2'd3, "R8");
    expectLk(32'h0030_1ABC, 1'b1, 32'h4440_1ABC, 2'd3, "R8");
    expectLk(32'h0010_7010, 1'b1, 32'h5550_7010, 2'd3, "R8");

    // R9: busy length, miss, dropped refill and retrigger during sweep
    doWrite(8'h20, 32'hFFFF_F000);
    doWrite(8'h24, 32'hFFFF_F000);
    doWrite(8'h18, 32'h1);
    busyCnt = rngBusy ? 1 : 0;
    lkValid = 1'b1; lkVa = 32'h0030_1ABC;
    rfValid = 1'b1; rfVa = 32'h0070_0000; rfPa = 32'h8888_8000; rfSize = 2'd0; rfPerm = 2'd3;
    regWe = 1'b1; regAddr = 8'h18; regWdata = 32'h1;
    @(negedge clk);
    lkValid = 1'b0; rfValid = 1'b0; regWe = 1'b0;
    check(rspValid === 1'b1 && rspHit === 1'b0, "R9", "hit during sweep",
          {31'b0, rspHit}, 32'd0);
    if (rngBusy) busyCnt++;
    while (rngBusy) begin
      @(negedge clk);
      if (rngBusy) busyCnt++;
    end
    check(busyCnt == SETS, "R9", "busy cycles", 32'(busyCnt), 32'(SETS));
    expectLk(32'h0070_0000, 1'b0, 32'h0, 2'd0, "R9");
    expectLk(32'h0030_1ABC, 1'b1, 32'h4440_1ABC, 2'd3, "R9");

    // R10: size code 3 dropped
    doRefill(32'h0090_0000, 32'h9990_0000, 2'd3, 2'd3);
    expectLk(32'h0090_0000, 1'b0, 32'h0, 2'd0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule